// File: doc/BRIEF.md
# Video Border Insertion and Recentering

This block accepts a 16-bit 4:2:2 YCbCr pixel stream on its own input clock and places that picture, unscaled, in the middle of a larger output raster. The output raster is generated afresh on a separate, faster output clock, with its own horizontal sync, vertical sync and data-enable. Each output word carries luma in bits 15:8 and chroma in bits 7:0. Positions outside the picture are filled with black. Positions inside the picture are read from a small line buffer that the input side writes.

By default a 640x480 picture sits in an 800x600 frame, with 80 black columns on each side and 60 black rows above and below. The output follows 800x600 timing at 60 Hz: 1056 clocks per line and 628 lines per frame. Both syncs are active high.

The output picture has to start later than the input frame, so the buffer holds a few complete input lines. The two sides exchange line counts as Gray-coded pointers. After reset, the output raster waits at the start of the last black row above the picture. It stays there until the first input line is complete, and from then on it runs freely. Two sticky flags report buffer faults:
- an overrun flag, on the input clock;
- an underrun flag, on the output clock.

Top module: `video_recenter`

## Requirements
- R1: While reset is asserted and just after it, the following are all low: out_de, out_hsync, out_vsync, ovf_err and unf_err.
- R2: Each output frame has exactly OUT_H lines with data-enable. Each of those lines has exactly OUT_W consecutive data-enable cycles, and there is no data-enable anywhere else.
- R3: Border words are 16'h1080, which is Y = 0x10 in bits 15:8 and chroma = 0x80 in bits 7:0. A line that carries picture has exactly 2*LB border words (LB = (OUT_W-IN_W)/2). Every other active line has OUT_W border words.
- R4: A line is OUT_W+H_FP+H_SYNC+H_BP clocks long, and out_hsync is high for H_SYNC clocks starting H_FP clocks after the active part. out_vsync is high for V_SYNC whole lines starting V_FP lines after the active lines. Neither sync is ever high while out_de is high.
- R5: Input pixel (r, c) appears unchanged at output row TB+r, column LB+c, where TB = (OUT_H-IN_H)/2. LB is even, so input column 0 (a Cb sample) lands on an even output column and the Cb/Cr alternation is preserved.
- R6: After reset the output raster is parked, with no data-enable and no sync pulses, until the first complete input line is in the buffer. It is parked at the start of output row TB-1. Once released, it runs on with no input.
- R7: An input line can be read only after its last pixel has been written. A rising edge of in_vsync restarts the input column count, so a partial line before it is discarded.
- R8: If a picture row begins on the output side while no complete line is buffered, unf_err is set and stays set, and the read line pointer does not advance for that row.
- R9: If an input line begins while LINES lines are still unread, the whole line is dropped and ovf_err is set and stays set. Buffer occupancy never exceeds LINES.
- R10: When input and output frame periods are equal, neither error flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input pixel clock |
| rst_in_n | input | 1 | Active-low asynchronous reset, input domain |
| in_valid | input | 1 | Input pixel qualifier |
| in_vsync | input | 1 | Input frame sync; a rising edge restarts the column count |
| in_data | input | 16 | Input pixel: luma in 15:8, alternating Cb/Cr in 7:0 |
| clk_out | input | 1 | Output pixel clock, faster than clk_in |
| rst_out_n | input | 1 | Active-low asynchronous reset, output domain |
| out_de | output | 1 | Output data-enable |
| out_hsync | output | 1 | Output horizontal sync, active high |
| out_vsync | output | 1 | Output vertical sync, active high |
| out_data | output | 16 | Output pixel word |
| ovf_err | output | 1 | Sticky buffer overrun flag (clk_in domain) |
| unf_err | output | 1 | Sticky buffer underrun flag (clk_out domain) |

## Verification
Two events can land in the same cycle. On the input side, the full test is made at the first pixel of a line. On the output side, the reader frees a slot at the end of a picture row. When both happen together, the read pointer seen by the writer is one line stale. The bench provokes this with a long back-to-back input burst while the raster keeps reading, so the buffer sits at the full mark and slots are freed during the burst. Judgement has two parts. The overrun flag must rise, and the occupancy bound must hold at every input clock throughout the burst.

// File: rtl/video_recenter.sv
module video_recenter #(
  parameter int IN_W   = 640,
  parameter int IN_H   = 480,
  parameter int OUT_W  = 800,
  parameter int OUT_H  = 600,
  parameter int H_FP   = 40,
  parameter int H_SYNC = 128,
  parameter int H_BP   = 88,
  parameter int V_FP   = 1,
  parameter int V_SYNC = 4,
  parameter int V_BP   = 23,
  parameter int LINES  = 4,
  parameter logic [15:0] BORDER = 16'h1080
) (
  input  logic        clk_in,
  input  logic        rst_in_n,
  input  logic        in_valid,
  input  logic        in_vsync,
  input  logic [15:0] in_data,
  input  logic        clk_out,
  input  logic        rst_out_n,
  output logic        out_de,
  output logic        out_hsync,
  output logic        out_vsync,
  output logic [15:0] out_data,
  output logic        ovf_err,
  output logic        unf_err
);
  localparam int LB    = (OUT_W - IN_W) / 2;
  localparam int TB    = (OUT_H - IN_H) / 2;
  localparam int HT    = OUT_W + H_FP + H_SYNC + H_BP;
  localparam int VT    = OUT_H + V_FP + V_SYNC + V_BP;
  localparam int LW    = $clog2(LINES);
  localparam int PW    = LW + 1;
  localparam int DEPTH = LINES * IN_W;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(IN_W);
  localparam int HW    = $clog2(HT);
  localparam int VW    = $clog2(VT);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [15:0] mem [DEPTH];

  // input side: line writer
  logic [CW-1:0] wcol;
  logic [PW-1:0] wptr, wgray, rg1, rg2, rgray;
  logic          vs_d, drop;

  wire [PW-1:0] rptr_w  = g2b(rg2);
  wire [PW-1:0] wocc    = wptr - rptr_w;
  wire          full    = (wocc == PW'(LINES));
  wire          vs_rise = in_vsync & ~vs_d;
  wire          skip    = (wcol == '0) ? full : drop;
  wire [AW-1:0] waddr   = AW'(wptr[LW-1:0]) * AW'(IN_W) + AW'(wcol);

  always_ff @(posedge clk_in or negedge rst_in_n) begin
    if (!rst_in_n) begin
      wcol <= '0; wptr <= '0; wgray <= '0; rg1 <= '0; rg2 <= '0;
      vs_d <= 1'b0; drop <= 1'b0; ovf_err <= 1'b0;
    end else begin
      vs_d  <= in_vsync;
      rg1   <= rgray;
      rg2   <= rg1;
      wgray <= wptr ^ (wptr >> 1);
      if (vs_rise) begin
        wcol <= '0;
        drop <= 1'b0;
      end else if (in_valid) begin
        if (wcol == '0) begin
          drop <= full;
          if (full) ovf_err <= 1'b1;
        end
        if (wcol == CW'(IN_W - 1)) begin
          wcol <= '0;
          if (!skip) wptr <= wptr + 1'b1;
        end else begin
          wcol <= wcol + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_in)
    if (in_valid && !vs_rise && !skip) mem[waddr] <= in_data;

  // output side: raster and reader
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [PW-1:0] rptr, wg1, wg2;
  logic          started, row_ok, img_q;
  logic [15:0]   ram_q;

  wire [PW-1:0] avail   = g2b(wg2) - rptr;
  wire          run     = started | (avail != '0);
  wire          img_row = (vcnt >= VW'(TB)) && (vcnt < VW'(TB + IN_H));
  wire          img_col = (hcnt >= HW'(LB)) && (hcnt < HW'(LB + IN_W));
  wire          active  = (hcnt < HW'(OUT_W)) && (vcnt < VW'(OUT_H));
  wire [CW-1:0] rcol    = img_col ? CW'(hcnt - HW'(LB)) : '0;
  wire [AW-1:0] raddr   = AW'(rptr[LW-1:0]) * AW'(IN_W) + AW'(rcol);

  always_ff @(posedge clk_out or negedge rst_out_n) begin
    if (!rst_out_n) begin
      hcnt <= '0; vcnt <= VW'(TB - 1); rptr <= '0; rgray <= '0;
      wg1 <= '0; wg2 <= '0; started <= 1'b0; row_ok <= 1'b0;
      out_de <= 1'b0; out_hsync <= 1'b0; out_vsync <= 1'b0;
      img_q <= 1'b0; unf_err <= 1'b0;
    end else begin
      wg1   <= wgray;
      wg2   <= wg1;
      rgray <= rptr ^ (rptr >> 1);
      if (run) begin
        started <= 1'b1;
        hcnt <= (hcnt == HW'(HT - 1)) ? '0 : hcnt + 1'b1;
        if (hcnt == HW'(HT - 1)) vcnt <= (vcnt == VW'(VT - 1)) ? '0 : vcnt + 1'b1;
        if (img_row && hcnt == '0) begin
          row_ok <= (avail != '0);
          if (avail == '0) unf_err <= 1'b1;
        end
        if (img_row && hcnt == HW'(LB + IN_W - 1) && row_ok) rptr <= rptr + 1'b1;
      end
      out_de    <= run && active;
      out_hsync <= run && (hcnt >= HW'(OUT_W + H_FP)) && (hcnt < HW'(OUT_W + H_FP + H_SYNC));
      out_vsync <= run && (vcnt >= VW'(OUT_H + V_FP)) && (vcnt < VW'(OUT_H + V_FP + V_SYNC));
      img_q     <= run && img_row && img_col;
    end
  end

  always_ff @(posedge clk_out) ram_q <= mem[raddr];

  assign out_data = img_q ? ram_q : BORDER;

  // checks
  logic [HW:0] hs_len, de_len;
  always_ff @(posedge clk_out or negedge rst_out_n) begin
    if (!rst_out_n) begin
      hs_len <= '0; de_len <= '0;
    end else begin
      hs_len <= out_hsync ? hs_len + 1'b1 : '0;
      de_len <= out_de ? de_len + 1'b1 : '0;
    end
  end

  AST_SYNC_OFF_IN_DE: assert property (@(posedge clk_out) disable iff (!rst_out_n)
    out_de |-> (!out_hsync && !out_vsync)); // R4
  AST_HSYNC_WIDTH: assert property (@(posedge clk_out) disable iff (!rst_out_n)
    $fell(out_hsync) |-> (hs_len == (HW+1)'(H_SYNC))); // R4
  AST_DE_WIDTH: assert property (@(posedge clk_out) disable iff (!rst_out_n)
    $fell(out_de) |-> (de_len == (HW+1)'(OUT_W))); // R2
  AST_OCC_BOUND: assert property (@(posedge clk_in) disable iff (!rst_in_n)
    wocc <= PW'(LINES)); // R9
endmodule

// File: tb/video_recenter_bench.sv
module video_recenter_bench;
  localparam int IN_W = 16, IN_H = 8, OUT_W = 24, OUT_H = 12;
  localparam int H_FP = 2, H_SYNC = 3, H_BP = 3, V_FP = 1, V_SYNC = 2, V_BP = 3;
  localparam int LINES = 4;
  localparam int HT = OUT_W + H_FP + H_SYNC + H_BP;
  localparam int LB = (OUT_W - IN_W) / 2, TB = (OUT_H - IN_H) / 2;
  localparam int IN_LINE = 20, IN_LINES = 18;
  localparam logic [15:0] BORDER = 16'h1080;

  logic clk_in = 0, clk_out = 0, rst_in_n = 0, rst_out_n = 0;
  logic in_valid = 0, in_vsync = 0;
  logic [15:0] in_data = '0;
  logic out_de, out_hsync, out_vsync, ovf_err, unf_err;
  logic [15:0] out_data;
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk_out = ~clk_out;
  always #8 clk_in = ~clk_in;

  video_recenter #(.IN_W(IN_W), .IN_H(IN_H), .OUT_W(OUT_W), .OUT_H(OUT_H),
    .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP), .V_FP(V_FP), .V_SYNC(V_SYNC),
    .V_BP(V_BP), .LINES(LINES), .BORDER(BORDER)) u_video_recenter (
    .clk_in(clk_in), .rst_in_n(rst_in_n), .in_valid(in_valid), .in_vsync(in_vsync),
    .in_data(in_data), .clk_out(clk_out), .rst_out_n(rst_out_n), .out_de(out_de),
    .out_hsync(out_hsync), .out_vsync(out_vsync), .out_data(out_data),
    .ovf_err(ovf_err), .unf_err(unf_err));

  function automatic logic [15:0] pat(input int r, input int c);
    logic [7:0] y, ch;
    y  = 8'(32 + r * 16 + c);
    ch = (c % 2 == 0) ? 8'(8'h40 + r) : 8'(8'hC0 + r);
    return {y, ch};
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk_out) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      summary();
    end
  end

  task automatic in_line(input int r, input bit vis, input bit vs, input int nvalid);
    for (int c = 0; c < IN_LINE; c++) begin
      @(negedge clk_in);
      in_vsync = vs;
      in_valid = vis && (c < nvalid);
      in_data  = vis ? pat(r, c) : 16'hDEAD;
    end
  endtask

  task automatic drive_frames(input int n);
    in_line(0, 1, 0, 5);          // partial junk line, to be dropped by the next vsync rise
    in_line(0, 0, 1, 0);
    for (int f = 0; f < n; f++)
      for (int l = 0; l < IN_LINES; l++) in_line(l, l < IN_H, l == 10, IN_W);
    @(negedge clk_in);
    in_valid = 0; in_vsync = 0;
  endtask

  task automatic capture_frame;
    int row = 0, col = 0, brd = 0, mism = 0, bad_w = 0, bad_b = 0, bad_hs = 0, hs_seen = 0;
    int hs_run = 0, vs_len = 0, fr = -1, fc = -1, extra = 0;
    logic prev_de = 0;
    @(negedge clk_out);
    while (out_vsync) @(negedge clk_out);
    while (!out_vsync) @(negedge clk_out);
    while (out_vsync) begin vs_len++; @(negedge clk_out); end
    check(vs_len == V_SYNC * HT, "R4", "vsync width in clocks", vs_len, V_SYNC * HT);
    while (row < OUT_H) begin
      if (out_de) begin
        bit in_img;
        logic [15:0] exp;
        in_img = row >= TB && row < TB + IN_H && col >= LB && col < LB + IN_W;
        exp = in_img ? pat(row - TB, col - LB) : BORDER;
        if (out_data !== exp) mism++;
        if (out_data == BORDER) brd++;
        if (fr < 0 && out_data != BORDER) begin fr = row; fc = col; end
        col++;
      end else if (prev_de) begin
        if (col != OUT_W) bad_w++;
        if (brd != ((row >= TB && row < TB + IN_H) ? 2 * LB : OUT_W)) bad_b++;
        row++; col = 0; brd = 0;
      end
      if (out_hsync) hs_run++;
      else if (hs_run != 0) begin hs_seen++; if (hs_run != H_SYNC) bad_hs++; hs_run = 0; end
      prev_de = out_de;
      @(negedge clk_out);
    end
    while (!out_vsync) begin if (out_de) extra++; @(negedge clk_out); end
    check(bad_w == 0, "R2", "lines with wrong data-enable length", bad_w, 0);
    check(extra == 0, "R2", "data-enable cycles after last active line", extra, 0);
    check(bad_b == 0, "R3", "lines with wrong border count", bad_b, 0);
    check(bad_hs == 0 && hs_seen >= OUT_H, "R4", "hsync pulses of wrong width", bad_hs, 0);
    check(mism == 0, "R5", "pixel mismatches (R7 line buffer)", mism, 0);
    check(fr == TB, "R5", "first picture row", fr, TB);
    check(fc == LB, "R5", "first picture column", fc, LB);
  endtask

  task automatic test_reset;
    #1;
    check(!out_de && !out_hsync && !out_vsync, "R1", "outputs in reset", {out_de, out_hsync, out_vsync}, 0);
    check(!ovf_err && !unf_err, "R1", "error flags in reset", {ovf_err, unf_err}, 0);
    #40;
    @(negedge clk_out); rst_out_n = 1;
    @(negedge clk_in);  rst_in_n = 1;
    @(negedge clk_out);
    check(!out_de && !out_hsync && !out_vsync, "R1", "outputs after reset", {out_de, out_hsync, out_vsync}, 0);
  endtask

  task automatic test_parked;
    int act = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_out);
      if (out_de || out_hsync || out_vsync) act++;
    end
    check(act == 0, "R6", "raster activity while parked without input", act, 0);
  endtask

  task automatic test_normal;
    fork
      drive_frames(5);
      begin
        capture_frame();
        capture_frame();
        check(!ovf_err && !unf_err, "R10", "error flags with matched rates", {ovf_err, unf_err}, 0);
      end
    join
  endtask

  task automatic test_underrun;
    int vs_rises = 0;
    logic pv = 0;
    for (int i = 0; i < 1300; i++) begin
      @(negedge clk_out);
      if (out_vsync && !pv) vs_rises++;
      pv = out_vsync;
    end
    check(vs_rises >= 2, "R6", "vsync pulses after input stopped", vs_rises, 2);
    check(unf_err == 1, "R8", "underrun flag", unf_err, 1);
    check(ovf_err == 0, "R8", "no overrun on underrun", ovf_err, 0);
  endtask

  task automatic test_overflow;
    for (int l = 0; l < 40; l++)
      for (int c = 0; c < IN_W; c++) begin
        @(negedge clk_in);
        in_valid = 1; in_vsync = 0; in_data = pat(l % IN_H, c);
      end
    @(negedge clk_in); in_valid = 0;
    @(negedge clk_in);
    check(ovf_err == 1, "R9", "overrun flag after burst", ovf_err, 1);
    check(unf_err == 1, "R8", "underrun flag stays set", unf_err, 1);
  endtask

  initial begin
    test_reset();
    test_parked();
    test_normal();
    test_underrun();
    test_overflow();
    summary();
  end
endmodule